// File: doc/BRIEF.md
# NOR Flash Command Sequencer

This block is a small bus master that runs write and erase commands on a 16-bit asynchronous NOR flash. A client asks for one operation through a start/busy/done handshake. The request carries a program-or-erase selector, a word address and data halfword for a program, and a signed first and last sector index for an erase. The sequencer then drives the flash bus with one write or one read per clock. It issues the two-write unlock preamble and the command writes, and polls bit 7 of the status word. The poll time is bounded by a cycle-count limit. Every operation that reached the bus ends with a read-array write (0x00F0). When an erase ends, a settle interval follows before done is raised.

The bank map is fixed and has eleven sectors. Word addresses are used throughout, so byte offsets are halved. Sector 0 starts at 0x00000, sector 1 at 0x02000, sector 2 at 0x03000 and sector 3 at 0x04000. Each sector n from 4 to 10 starts at 0x20000·(n−3). Each sector has a protect bit that can be written through a side port. At reset, every sector whose start lies below word 0x20000 is protected. An erase is checked against its whole range before any write is issued.

Top module: `nfl_cmd_seq`

## Requirements
- R1: A start pulse seen while busy is low is accepted: busy is high on the next cycle. Done is a one-cycle pulse raised in the same cycle that busy falls, and status is valid from that cycle. Status codes are 0 ok, 1 protected, 2 timeout, 3 program error and 4 invalid argument.
- R2: A start pulse seen while busy is high has no effect. No extra bus cycle is issued and the running operation's result is unchanged.
- R3: A program issues exactly these writes, in order: 0x00AA to word 0x555, 0x0055 to word 0x2AA, 0x00A0 to word 0x555, and then the data halfword to the target word address.
- R4: A program poll succeeds when bit 7 of the read equals bit 7 of the data. The sequencer then writes 0x00F0 to the target address and reads the target back. It reports 0 if the read-back value equals the data and 3 otherwise.
- R5: Each erased sector gets six writes: 0x00AA to 0x555, 0x0055 to 0x2AA, 0x0080 to 0x555, 0x00AA to 0x555, 0x0055 to 0x2AA, and then 0x0030 to the sector's start. Polling at that start completes when bit 7 reads 1, and 0x00F0 is then written to 0x555.
- R6: The sectors of an erase are processed one at a time, in ascending order from the first index to the last.
- R7: An erase whose first index is negative, whose first index is greater than its last, or whose last index is above 10 reports 4 and issues no bus cycle.
- R8: An erase whose range contains any protected sector reports 1 and issues no bus cycle. After reset sectors 0 to 3 are protected and sectors 4 to 10 are not. The protect port sets or clears one sector's bit.
- R9: Sector start word addresses follow the fixed map: 0x00000, 0x02000, 0x03000 and 0x04000 for sectors 0 to 3, and 0x20000·(n−3) for sectors n from 4 to 10.
- R10: Polling cycles are counted from 1 at the first status check and advance by 2 per further check. A check at which the count has reached TMO_CYC reports 2, even if that same read shows completion. The sequencer writes 0x00F0 (to 0x555 for an erase, to the target for a program) and processes no further sector.
- R11: After the final read-array write of an erase, done rises no sooner than SETTLE_CYC cycles later.
- R12: After reset, busy, done, the write strobe and the read strobe are low and status is 0. A write and a read are never issued in the same cycle, and the bus is quiet while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse |
| req_erase | input | 1 | 1 selects sector erase, 0 selects halfword program |
| req_addr | input | ADDR_W | Program target word address |
| req_data | input | 16 | Program data |
| req_first | input | SIDX_W | First sector index, signed |
| req_last | input | SIDX_W | Last sector index, signed |
| prot_wr_en | input | 1 | Protect bit write enable |
| prot_wr_sect | input | clog2(NSECT) | Sector whose protect bit is written |
| prot_wr_val | input | 1 | New protect bit value |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 3 | Result code |
| fl_addr | output | ADDR_W | Flash word address |
| fl_wdata | output | 16 | Flash write data |
| fl_we | output | 1 | Flash write strobe, one cycle per write |
| fl_re | output | 1 | Flash read strobe, one cycle per read |
| fl_rdata | input | 16 | Flash read data, valid while fl_re is high |

## Verification
The point of contention is the status check at which the poll-cycle count reaches its limit while the flash reports completion on the same read. The bench shortens the timeout so that the fifth check lands exactly on the limit. It sets the flash model to report completion on that fifth read, and expects a timeout, with read-array following and the remaining sectors skipped. A second run makes the model finish one read earlier and expects ok. A further run raises a new start while an erase is in progress, and the write scoreboard shows that no extra cycle appeared.

// File: rtl/nfl_pkg.sv
package nfl_pkg;

  typedef enum logic [2:0] {
    ST_OK    = 3'd0,
    ST_PROT  = 3'd1,
    ST_TMO   = 3'd2,
    ST_PERR  = 3'd3,
    ST_INVAL = 3'd4
  } nfl_status_e;

  localparam logic [15:0] D_UNL1   = 16'h00AA;
  localparam logic [15:0] D_UNL2   = 16'h0055;
  localparam logic [15:0] D_ESETUP = 16'h0080;
  localparam logic [15:0] D_ECONF  = 16'h0030;
  localparam logic [15:0] D_PROG   = 16'h00A0;
  localparam logic [15:0] D_RDARR  = 16'h00F0;

  localparam logic [31:0] A_UNL1 = 32'h0000_0555;
  localparam logic [31:0] A_UNL2 = 32'h0000_02AA;

  // word-address sector starts for the fixed boot-block layout
  localparam logic [31:0] BIG_SECT_WORDS = 32'h0002_0000;

  function automatic logic [31:0] sect_base(input logic [31:0] idx);
    case (idx)
      32'd0:   sect_base = 32'h0000_0000;
      32'd1:   sect_base = 32'h0000_2000;
      32'd2:   sect_base = 32'h0000_3000;
      32'd3:   sect_base = 32'h0000_4000;
      default: sect_base = BIG_SECT_WORDS * (idx - 32'd3);
    endcase
  endfunction

endpackage

// File: rtl/nfl_sector_map.sv
module nfl_sector_map #(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned IDX_W  = 4
) (
  input  logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] base
);
  logic [31:0] base_full;

  always_comb begin
    base_full = nfl_pkg::sect_base(32'(idx));
    base      = base_full[ADDR_W-1:0];
  end
endmodule

// File: rtl/nfl_protect_bank.sv
module nfl_protect_bank #(
  parameter int unsigned    NSECT      = 11,
  parameter int unsigned    IDX_W      = 4,
  parameter int unsigned    ADDR_W     = 20,
  parameter logic [31:0]    PROT_LIMIT = 32'h0002_0000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_sect,
  input  logic             wr_val,
  input  logic [IDX_W-1:0] first,
  input  logic [IDX_W-1:0] last,
  output logic             hit
);
  logic [NSECT-1:0] prot_bits;
  logic [NSECT-1:0] in_range;

  for (genvar g = 0; g < NSECT; g++) begin : g_sect
    localparam logic [31:0] BASE_G = nfl_pkg::sect_base(32'(g));
    localparam logic RST_VAL = (BASE_G[ADDR_W-1:0] < PROT_LIMIT[ADDR_W-1:0]);

    always_ff @(posedge clk) begin
      if (rst)
        prot_bits[g] <= RST_VAL;
      else if (wr_en && (wr_sect == IDX_W'(g)))
        prot_bits[g] <= wr_val;
    end

    assign in_range[g] = (IDX_W'(g) >= first) && (IDX_W'(g) <= last);
  end

  assign hit = |(prot_bits & in_range);
endmodule

// File: rtl/nfl_wait_timer.sv
module nfl_wait_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic [W-1:0] limit,
  output logic         expired
);
  logic [W-1:0] cnt;

  assign expired = (cnt >= limit);

  always_ff @(posedge clk) begin
    if (rst || !run)
      cnt <= '0;
    else if (!expired)
      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/nfl_cmd_seq.sv
module nfl_cmd_seq #(
  parameter int unsigned ADDR_W     = 20,
  parameter int unsigned NSECT      = 11,
  parameter int unsigned SIDX_W     = 5,
  parameter int unsigned TMO_CYC    = 6250000,
  parameter int unsigned SETTLE_CYC = 1250000,
  parameter logic [31:0] PROT_LIMIT = 32'h0002_0000
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start,
  input  logic                       req_erase,
  input  logic [ADDR_W-1:0]          req_addr,
  input  logic [15:0]                req_data,
  input  logic signed [SIDX_W-1:0]   req_first,
  input  logic signed [SIDX_W-1:0]   req_last,
  input  logic                       prot_wr_en,
  input  logic [$clog2(NSECT)-1:0]   prot_wr_sect,
  input  logic                       prot_wr_val,
  output logic                       busy,
  output logic                       done,
  output logic [2:0]                 status,
  output logic [ADDR_W-1:0]          fl_addr,
  output logic [15:0]                fl_wdata,
  output logic                       fl_we,
  output logic                       fl_re,
  input  logic [15:0]                fl_rdata
);
  import nfl_pkg::*;

  localparam int unsigned IDX_W   = $clog2(NSECT);
  localparam int unsigned LIM_MAX = (TMO_CYC > SETTLE_CYC) ? TMO_CYC : SETTLE_CYC;
  localparam int unsigned LIM_W   = $clog2(LIM_MAX + 1);
  localparam logic [ADDR_W-1:0] ADR_U1 = A_UNL1[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] ADR_U2 = A_UNL2[ADDR_W-1:0];

  typedef enum logic [3:0] {
    S_IDLE, S_CHECK, S_CMD, S_POLL_RD, S_POLL_CHK,
    S_RA, S_VER_RD, S_VER_CHK, S_SETTLE, S_FINISH
  } state_e;

  state_e                    state;
  logic                      erase_q;
  logic [ADDR_W-1:0]         addr_q;
  logic [15:0]               data_q;
  logic signed [SIDX_W-1:0]  first_q;
  logic signed [SIDX_W-1:0]  last_q;
  logic [IDX_W-1:0]          cur_q;
  logic [2:0]                step_q;
  logic                      tmo_q;
  nfl_status_e               st_q;

  logic [ADDR_W-1:0]         sect_addr;
  logic [ADDR_W-1:0]         tgt_addr;
  logic                      prot_hit;
  logic                      args_bad;
  logic                      tmr_run;
  logic                      tmr_exp;
  logic [LIM_W-1:0]          tmr_limit;
  logic [ADDR_W-1:0]         cmd_addr;
  logic [15:0]               cmd_data;
  logic [2:0]                last_step;
  logic                      poll_ok;

  nfl_sector_map #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_map (
    .idx  (cur_q),
    .base (sect_addr)
  );

  nfl_protect_bank #(
    .NSECT(NSECT), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .PROT_LIMIT(PROT_LIMIT)
  ) u_prot (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (prot_wr_en),
    .wr_sect (prot_wr_sect),
    .wr_val  (prot_wr_val),
    .first   (first_q[IDX_W-1:0]),
    .last    (last_q[IDX_W-1:0]),
    .hit     (prot_hit)
  );

  assign tmr_run   = (state == S_POLL_RD) || (state == S_POLL_CHK) || (state == S_SETTLE);
  assign tmr_limit = (state == S_SETTLE) ? LIM_W'(SETTLE_CYC) : LIM_W'(TMO_CYC);

  nfl_wait_timer #(.W(LIM_W)) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .run     (tmr_run),
    .limit   (tmr_limit),
    .expired (tmr_exp)
  );

  assign tgt_addr  = erase_q ? sect_addr : addr_q;
  assign last_step = erase_q ? 3'd5 : 3'd3;
  assign args_bad  = (first_q < 0) || (first_q > last_q) ||
                     (last_q > $signed((SIDX_W+1)'(NSECT - 1)));
  assign poll_ok   = erase_q ? fl_rdata[7] : (fl_rdata[7] == data_q[7]);

  // command write generator: erase uses steps 0..5, program steps 0..3
  always_comb begin
    cmd_addr = tgt_addr;
    cmd_data = erase_q ? D_ECONF : data_q;
    case (step_q)
      3'd0: begin cmd_addr = ADR_U1; cmd_data = D_UNL1; end
      3'd1: begin cmd_addr = ADR_U2; cmd_data = D_UNL2; end
      3'd2: begin cmd_addr = ADR_U1; cmd_data = erase_q ? D_ESETUP : D_PROG; end
      3'd3: if (erase_q) begin cmd_addr = ADR_U1; cmd_data = D_UNL1; end
      3'd4: begin cmd_addr = ADR_U2; cmd_data = D_UNL2; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      busy     <= 1'b0;
      done     <= 1'b0;
      status   <= 3'd0;
      fl_we    <= 1'b0;
      fl_re    <= 1'b0;
      fl_addr  <= '0;
      fl_wdata <= '0;
      erase_q  <= 1'b0;
      addr_q   <= '0;
      data_q   <= '0;
      first_q  <= '0;
      last_q   <= '0;
      cur_q    <= '0;
      step_q   <= '0;
      tmo_q    <= 1'b0;
      st_q     <= ST_OK;
    end else begin
      fl_we <= 1'b0;
      fl_re <= 1'b0;
      done  <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            busy    <= 1'b1;
            erase_q <= req_erase;
            addr_q  <= req_addr;
            data_q  <= req_data;
            first_q <= req_first;
            last_q  <= req_last;
            step_q  <= '0;
            tmo_q   <= 1'b0;
            st_q    <= ST_OK;
            state   <= req_erase ? S_CHECK : S_CMD;
          end
        end
        S_CHECK: begin
          if (args_bad) begin
            st_q  <= ST_INVAL;
            state <= S_FINISH;
          end else if (prot_hit) begin
            st_q  <= ST_PROT;
            state <= S_FINISH;
          end else begin
            cur_q  <= first_q[IDX_W-1:0];
            step_q <= '0;
            state  <= S_CMD;
          end
        end
        S_CMD: begin
          fl_we    <= 1'b1;
          fl_addr  <= cmd_addr;
          fl_wdata <= cmd_data;
          step_q   <= step_q + 3'd1;
          if (step_q == last_step)
            state <= S_POLL_RD;
        end
        S_POLL_RD: begin
          fl_re   <= 1'b1;
          fl_addr <= tgt_addr;
          state   <= S_POLL_CHK;
        end
        S_POLL_CHK: begin
          if (tmr_exp) begin
            tmo_q <= 1'b1;
            st_q  <= ST_TMO;
            state <= S_RA;
          end else if (poll_ok) begin
            state <= S_RA;
          end else begin
            state <= S_POLL_RD;
          end
        end
        S_RA: begin
          fl_we    <= 1'b1;
          fl_wdata <= D_RDARR;
          fl_addr  <= erase_q ? ADR_U1 : addr_q;
          if (erase_q) begin
            if (tmo_q || (cur_q == last_q[IDX_W-1:0])) begin
              state <= S_SETTLE;
            end else begin
              cur_q  <= cur_q + 1'b1;
              step_q <= '0;
              state  <= S_CMD;
            end
          end else begin
            state <= tmo_q ? S_FINISH : S_VER_RD;
          end
        end
        S_VER_RD: begin
          fl_re   <= 1'b1;
          fl_addr <= addr_q;
          state   <= S_VER_CHK;
        end
        S_VER_CHK: begin
          st_q  <= (fl_rdata == data_q) ? ST_OK : ST_PERR;
          state <= S_FINISH;
        end
        S_SETTLE: begin
          if (tmr_exp)
            state <= S_FINISH;
        end
        S_FINISH: begin
          done   <= 1'b1;
          busy   <= 1'b0;
          status <= st_q;
          state  <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nfl_cmd_seq_chk.sv
module nfl_cmd_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic [2:0] status,
  input logic       fl_we,
  input logic       fl_re
);
  // R12: one bus operation per cycle
  p_we_re_excl_r12: assert property (@(posedge clk) disable iff (rst)
    !(fl_we && fl_re));

  // R12: bus is quiet while no operation is in progress
  p_bus_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!fl_we && !fl_re));

  // R1: an idle start is taken
  p_accept_r1: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  // R1: done lasts one cycle
  p_done_pulse_r1: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R1: done coincides with the end of busy
  p_done_idle_r1: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  p_busy_fall_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  // R2: the reported result only moves with done
  p_status_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !$stable(status) |-> done);
endmodule

bind nfl_cmd_seq nfl_cmd_seq_chk u_chk (
  .clk    (clk),
  .rst    (rst),
  .start  (start),
  .busy   (busy),
  .done   (done),
  .status (status),
  .fl_we  (fl_we),
  .fl_re  (fl_re)
);

// File: tb/nfl_cmd_seq_bench.sv
module nfl_cmd_seq_bench;
  localparam int TMO  = 9;
  localparam int SETL = 20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        req_erase = 1'b0;
  logic [19:0] req_addr = '0;
  logic [15:0] req_data = '0;
  logic signed [4:0] req_first = '0;
  logic signed [4:0] req_last = '0;
  logic        prot_wr_en = 1'b0;
  logic [3:0]  prot_wr_sect = '0;
  logic        prot_wr_val = 1'b0;
  logic        busy, done, fl_we, fl_re;
  logic [2:0]  status;
  logic [19:0] fl_addr;
  logic [15:0] fl_wdata;
  logic [15:0] fl_rdata;

  always #4 clk = ~clk;

  nfl_cmd_seq #(.TMO_CYC(TMO), .SETTLE_CYC(SETL)) u_nfl_cmd_seq (
    .clk(clk), .rst(rst), .start(start), .req_erase(req_erase),
    .req_addr(req_addr), .req_data(req_data), .req_first(req_first),
    .req_last(req_last), .prot_wr_en(prot_wr_en), .prot_wr_sect(prot_wr_sect),
    .prot_wr_val(prot_wr_val), .busy(busy), .done(done), .status(status),
    .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_we(fl_we), .fl_re(fl_re),
    .fl_rdata(fl_rdata)
  );

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int last_we_cyc = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input string what);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: %s", req, what);
    end
  endtask

  // flash model
  logic        m_active, m_prog, m_prev_a0;
  logic [15:0] m_pdata;
  int          m_reads;
  int          ready_after = 2;
  bit          corrupt = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_active <= 1'b0; m_prog <= 1'b0; m_prev_a0 <= 1'b0;
      m_pdata <= 16'h0; m_reads <= 0;
    end else if (fl_we) begin
      m_reads   <= 0;
      m_active  <= (fl_wdata != 16'h00F0);
      if (m_prev_a0) begin m_pdata <= fl_wdata; m_prog <= 1'b1; end
      if (fl_wdata == 16'h0080) m_prog <= 1'b0;
      m_prev_a0 <= (fl_addr == 20'h555) && (fl_wdata == 16'h00A0);
    end else if (fl_re) begin
      m_reads <= m_reads + 1;
    end
  end

  always_comb begin
    if (!m_active)
      fl_rdata = corrupt ? (m_pdata ^ 16'h0100) : m_pdata;
    else if (m_prog)
      fl_rdata = (m_reads >= ready_after) ? m_pdata : ~m_pdata;
    else
      fl_rdata = (m_reads >= ready_after) ? 16'hFFFF : 16'h0000;
  end

  // scoreboard of expected bus writes
  logic [35:0] exp_q[$];

  task automatic push_wr(input logic [19:0] a, input logic [15:0] d);
    exp_q.push_back({a, d});
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst && fl_we) begin
      last_we_cyc = cyc;
      if (exp_q.size() == 0) begin
        check(1'b0, "R2", $sformatf("unexpected write actual=%05h/%04h expected=none",
              fl_addr, fl_wdata));
      end else begin
        logic [35:0] e;
        e = exp_q.pop_front();
        check({fl_addr, fl_wdata} == e, "R3/R5/R6/R9",
              $sformatf("write actual=%05h/%04h expected=%05h/%04h",
                        fl_addr, fl_wdata, e[35:16], e[15:0]));
      end
    end
  end

  function automatic logic [19:0] base_of(input int s);
    case (s)
      0: return 20'h00000;
      1: return 20'h02000;
      2: return 20'h03000;
      3: return 20'h04000;
      default: return 20'(32'h20000 * (s - 3));
    endcase
  endfunction

  task automatic exp_erase_sector(input int s);
    push_wr(20'h555, 16'h00AA); push_wr(20'h2AA, 16'h0055);
    push_wr(20'h555, 16'h0080); push_wr(20'h555, 16'h00AA);
    push_wr(20'h2AA, 16'h0055); push_wr(base_of(s), 16'h0030);
    push_wr(20'h555, 16'h00F0);
  endtask

  task automatic exp_prog(input logic [19:0] a, input logic [15:0] d);
    push_wr(20'h555, 16'h00AA); push_wr(20'h2AA, 16'h0055);
    push_wr(20'h555, 16'h00A0); push_wr(a, d);
    push_wr(a, 16'h00F0);
  endtask

  task automatic run_op(input bit er, input logic [19:0] a, input logic [15:0] d,
                        input int f, input int l, input logic [2:0] exp_st,
                        input bit chk_settle, input string req);
    int done_cyc;
    @(negedge clk);
    req_erase = er; req_addr = a; req_data = d;
    req_first = 5'(f); req_last = 5'(l); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R1", $sformatf("busy after start actual=%0b expected=1", busy));
    do @(negedge clk); while (!done && !finished);
    done_cyc = cyc;
    check(status == exp_st, req, $sformatf("status actual=%0d expected=%0d", status, exp_st));
    check(busy == 1'b0, "R1", $sformatf("busy at done actual=%0b expected=0", busy));
    check(exp_q.size() == 0, req, $sformatf("pending writes actual=%0d expected=0", exp_q.size()));
    if (chk_settle)
      check((done_cyc - last_we_cyc >= SETL) && (done_cyc - last_we_cyc <= SETL + 3), "R11",
            $sformatf("settle gap actual=%0d expected>=%0d", done_cyc - last_we_cyc, SETL));
    @(negedge clk);
    check(done == 1'b0, "R1", $sformatf("done width actual=%0b expected=0", done));
  endtask

  task automatic set_prot(input int s, input bit v);
    @(negedge clk);
    prot_wr_en = 1'b1; prot_wr_sect = 4'(s); prot_wr_val = v;
    @(negedge clk);
    prot_wr_en = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL R1: watchdog actual=busy expected=idle");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    check(!busy && !done && !fl_we && !fl_re && status == 3'd0, "R12",
          $sformatf("reset actual=%0b%0b%0b%0b/%0d expected=0000/0", busy, done, fl_we, fl_re, status));

    // R3 R4 program ok
    ready_after = 2; corrupt = 0;
    exp_prog(20'h12345, 16'hBEEF);
    run_op(0, 20'h12345, 16'hBEEF, 0, 0, 3'd0, 0, "R4");

    // R4 readback mismatch
    corrupt = 1;
    exp_prog(20'h00777, 16'h5A3C);
    run_op(0, 20'h00777, 16'h5A3C, 0, 0, 3'd3, 0, "R4");
    corrupt = 0;

    // R10 program timeout: read-array to target, no verify read
    ready_after = 100;
    exp_prog(20'h40000, 16'h0081);
    run_op(0, 20'h40000, 16'h0081, 0, 0, 3'd2, 0, "R10");

    // R8 protected at reset
    run_op(1, 0, 0, 3, 3, 3'd1, 0, "R8");
    run_op(1, 0, 0, 2, 6, 3'd1, 0, "R8");

    // R7 invalid arguments
    run_op(1, 0, 0, -1, 4, 3'd4, 0, "R7");
    run_op(1, 0, 0, 6, 5, 3'd4, 0, "R7");
    run_op(1, 0, 0, 9, 11, 3'd4, 0, "R7");

    // R5 R6 R9 R11 two unprotected sectors
    ready_after = 2;
    exp_erase_sector(4); exp_erase_sector(5);
    run_op(1, 0, 0, 4, 5, 3'd0, 1, "R6");

    // R8 R9 clear protection and erase boot sectors
    set_prot(1, 0); set_prot(2, 0); set_prot(3, 0); set_prot(0, 0);
    exp_erase_sector(0); exp_erase_sector(1); exp_erase_sector(2); exp_erase_sector(3);
    run_op(1, 0, 0, 0, 3, 3'd0, 1, "R9");
    set_prot(10, 1);
    run_op(1, 0, 0, 8, 10, 3'd1, 0, "R8");
    set_prot(10, 0);

    // R10 completion one read before the limit: ok
    ready_after = 3;
    exp_erase_sector(10);
    run_op(1, 0, 0, 10, 10, 3'd0, 1, "R10");

    // R10 completion and timeout on the same check: timeout wins, sector 10 skipped
    ready_after = 4;
    exp_erase_sector(9);
    run_op(1, 0, 0, 9, 10, 3'd2, 1, "R10");

    // R2 start while busy is ignored
    ready_after = 2;
    exp_erase_sector(7);
    fork
      run_op(1, 0, 0, 7, 7, 3'd0, 1, "R2");
      begin
        repeat (6) @(negedge clk);
        req_erase = 1'b0; req_addr = 20'h00100; req_data = 16'h1234;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
      end
    join
    repeat (3) @(negedge clk);
    check(busy == 1'b0 && exp_q.size() == 0, "R2",
          $sformatf("after ignored start busy actual=%0b expected=0", busy));

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule